// File: doc/BRIEF.md
# Command Frame Header Router

This block sits behind a host-side receive buffer and takes in an unbroken byte stream made of command frames. The first byte of each frame is a header. The router decodes it to learn two things: how many payload bytes follow, and which endpoint the frame is meant for. It then steers the whole frame, header byte included, to one of two byte outputs. Frames for the local hardware endpoint go out on a local command port. Frames for any of the three remote endpoints go out on a remote byte-transfer port.

Frames are handled one at a time, in the order they arrive. The block stores no data. Each input byte passes straight through to the selected output under valid/ready handshakes, so a stall on the chosen output holds the input byte in place. The frame ID tag of the most recently accepted header is kept on a plain output so that responses can be matched to commands. A header whose must-be-zero bit is set produces a one-cycle error pulse. That frame is still routed and counted normally, so the stream stays aligned on frame boundaries.

Top module: `cmd_frame_router`

## Requirements
- R1: After an active-high synchronous reset (`rst`), the router waits for a header. `loc_valid`, `rem_valid` and `hdr_err` are low, and `last_tag` is 0. A frame that was only partly transferred when reset arrived is dropped, and the next byte accepted is decoded as a header.
- R2: The length code in header bits 1..0 sets the payload size: 0 means 1 byte, 1 means 4, 2 means 32 and 3 means 512. A frame is the payload plus its header byte. The `*_last` flag is high exactly on the final payload byte of a frame.
- R3: A header whose endpoint field (bits 4..3) is 0 sends that header and its whole payload to the local port.
- R4: A header with endpoint field 1, 2 or 3 sends that header and its whole payload, unchanged, to the remote port.
- R5: The `*_first` flag is high on the header byte of a frame and low on every payload byte.
- R6: Back-pressure rule. `in_ready` equals the ready input of the port that the current byte is routed to. An output's valid is high only while `in_valid` is high. A byte counts as moved only in a cycle where both valid and ready are high, so no byte is ever lost or duplicated.
- R7: At most one of `loc_valid` and `rem_valid` is high in any cycle. The ready input of the port that is not selected has no effect on `in_ready`.
- R8: When a header with bit 2 set is accepted, `hdr_err` is high for exactly the following cycle. That frame is still forwarded and counted by its length code.
- R9: `last_tag` takes header bits 6..5 in the cycle after a header is accepted, and holds that value until the next header is accepted.
- R10: Header bit 7 (reserved) has no effect on routing or on length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte is present |
| in_data | input | 8 | Input byte from the host-side buffer |
| in_ready | output | 1 | Router takes the input byte this cycle |
| loc_valid | output | 1 | Byte offered to the local port |
| loc_data | output | 8 | Local port byte |
| loc_first | output | 1 | Local byte is a frame header |
| loc_last | output | 1 | Local byte ends the frame |
| loc_ready | input | 1 | Local port accepts the byte |
| rem_valid | output | 1 | Byte offered to the remote port |
| rem_data | output | 8 | Remote port byte |
| rem_first | output | 1 | Remote byte is a frame header |
| rem_last | output | 1 | Remote byte ends the frame |
| rem_ready | input | 1 | Remote port accepts the byte |
| last_tag | output | 2 | Frame ID tag of the last accepted header |
| hdr_err | output | 1 | One-cycle pulse after a header with bit 2 set |

## Verification
Two things can fall in the same cycle. A frame's last byte is followed at once by the next frame's header, which may go to the other port. And the error pulse from a faulty header lands in the same cycle as that frame's first payload transfer. The bench provokes both by queuing frames back to back with no idle gap. It includes short 1-byte frames with bit 2 set, and it runs with random stalls on both ports. A behavioural model then checks on every clock that the port choice switches exactly on the frame boundary and that the pulse neither blocks nor shifts the payload handshake.

// File: rtl/cfr_pkg.sv
package cfr_pkg;

  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned MAX_PAY  = 512;
  localparam int unsigned CNT_W    = $clog2(MAX_PAY + 1);

  typedef struct packed {
    logic       rsvd;
    logic [1:0] tag;
    logic [1:0] ep;
    logic       mbz;
    logic [1:0] len;
  } cmd_hdr_t;

  // Non-linear size code: 1, 4, 32, 512 payload bytes.
  function automatic logic [CNT_W-1:0] pay_bytes(input logic [1:0] code);
    logic [3:0] sh;
    case (code)
      2'd0:    sh = 4'd0;
      2'd1:    sh = 4'd2;
      2'd2:    sh = 4'd5;
      default: sh = 4'd9;
    endcase
    return CNT_W'(1) << sh;
  endfunction

endpackage

// File: rtl/cfr_hdr_decode.sv
module cfr_hdr_decode
  import cfr_pkg::*;
#(
  parameter int unsigned LOCAL_EP = 0
) (
  input  logic [BYTE_W-1:0] byte_in,
  output logic [1:0]        tag,
  output logic              is_local,
  output logic              mbz_set,
  output logic [CNT_W-1:0]  pay_len
);
  cmd_hdr_t h;

  always_comb begin
    h        = cmd_hdr_t'(byte_in);
    tag      = h.tag;
    is_local = (h.ep == 2'(LOCAL_EP));
    mbz_set  = h.mbz;
    pay_len  = pay_bytes(h.len);
  end
endmodule

// File: rtl/cfr_frame_seq.sv
module cfr_frame_seq
  import cfr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             xfer,
  input  logic [CNT_W-1:0] hdr_len,
  output logic             at_hdr,
  output logic             at_last
);
  logic [CNT_W-1:0] left_q;
  logic             hdr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_q  <= 1'b1;
      left_q <= '0;
    end else if (xfer) begin
      if (hdr_q) begin
        hdr_q  <= 1'b0;
        left_q <= hdr_len;
      end else if (left_q == CNT_W'(1)) begin
        hdr_q  <= 1'b1;
        left_q <= '0;
      end else begin
        left_q <= left_q - CNT_W'(1);
      end
    end
  end

  assign at_hdr  = hdr_q;
  assign at_last = !hdr_q && (left_q == CNT_W'(1));
endmodule

// File: rtl/cfr_steer.sv
module cfr_steer
  import cfr_pkg::*;
(
  input  logic              to_local,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              loc_ready,
  input  logic              rem_ready,
  output logic              loc_valid,
  output logic              rem_valid,
  output logic              xfer
);
  always_comb begin
    in_ready  = to_local ? loc_ready : rem_ready;
    loc_valid = in_valid &&  to_local;
    rem_valid = in_valid && !to_local;
    xfer      = in_valid && in_ready;
  end
endmodule

// File: rtl/cmd_frame_router.sv
module cmd_frame_router
  import cfr_pkg::*;
#(
  parameter int unsigned LOCAL_EP = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  output logic              loc_valid,
  output logic [BYTE_W-1:0] loc_data,
  output logic              loc_first,
  output logic              loc_last,
  input  logic              loc_ready,
  output logic              rem_valid,
  output logic [BYTE_W-1:0] rem_data,
  output logic              rem_first,
  output logic              rem_last,
  input  logic              rem_ready,
  output logic [1:0]        last_tag,
  output logic              hdr_err
);
  logic [1:0]       dec_tag;
  logic             dec_local;
  logic             dec_mbz;
  logic [CNT_W-1:0] dec_len;
  logic             at_hdr, at_last, xfer, to_local;
  logic             route_local_q;
  logic [1:0]       tag_q;
  logic             err_q;

  cfr_hdr_decode #(.LOCAL_EP(LOCAL_EP)) u_dec (
    .byte_in  (in_data),
    .tag      (dec_tag),
    .is_local (dec_local),
    .mbz_set  (dec_mbz),
    .pay_len  (dec_len)
  );

  cfr_frame_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .xfer    (xfer),
    .hdr_len (dec_len),
    .at_hdr  (at_hdr),
    .at_last (at_last)
  );

  // Header bytes route on their own decode; payload follows the latched route.
  assign to_local = at_hdr ? dec_local : route_local_q;

  cfr_steer u_steer (
    .to_local  (to_local),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .loc_ready (loc_ready),
    .rem_ready (rem_ready),
    .loc_valid (loc_valid),
    .rem_valid (rem_valid),
    .xfer      (xfer)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      route_local_q <= 1'b0;
      tag_q         <= '0;
      err_q         <= 1'b0;
    end else begin
      err_q <= xfer && at_hdr && dec_mbz;
      if (xfer && at_hdr) begin
        route_local_q <= dec_local;
        tag_q         <= dec_tag;
      end
    end
  end

  assign loc_data  = in_data;
  assign rem_data  = in_data;
  assign loc_first = at_hdr;
  assign rem_first = at_hdr;
  assign loc_last  = at_last;
  assign rem_last  = at_last;
  assign last_tag  = tag_q;
  assign hdr_err   = err_q;
endmodule

// File: rtl/cfr_checker.sv
module cfr_checker (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic [7:0] in_data,
  input logic       in_ready,
  input logic       loc_valid,
  input logic [7:0] loc_data,
  input logic       loc_first,
  input logic       loc_last,
  input logic       loc_ready,
  input logic       rem_valid,
  input logic [7:0] rem_data,
  input logic       rem_first,
  input logic       rem_last,
  input logic       rem_ready,
  input logic [1:0] last_tag,
  input logic       hdr_err
);
  logic hdr_acc;
  assign hdr_acc = (loc_valid && loc_ready && loc_first) ||
                   (rem_valid && rem_ready && rem_first);

  assert_one_target_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({loc_valid, rem_valid}));

  assert_local_hdr_R3: assert property (@(posedge clk) disable iff (rst)
    (loc_valid && loc_first) |-> (loc_data[4:3] == 2'd0));

  assert_remote_hdr_R4: assert property (@(posedge clk) disable iff (rst)
    (rem_valid && rem_first) |-> (rem_data[4:3] != 2'd0));

  assert_valid_needs_input_R6: assert property (@(posedge clk) disable iff (rst)
    (loc_valid || rem_valid) |-> in_valid);

  assert_hold_remote_R6: assert property (@(posedge clk) disable iff (rst)
    (rem_valid && !rem_ready && in_valid) |=> (!in_valid || (rem_valid && $stable(rem_data))));

  assert_hdr_not_last_R2: assert property (@(posedge clk) disable iff (rst)
    (loc_valid && loc_first) |-> !loc_last);

  assert_err_cause_R8: assert property (@(posedge clk) disable iff (rst)
    hdr_err |-> $past(hdr_acc && in_data[2]));

  assert_tag_load_R9: assert property (@(posedge clk) disable iff (rst)
    hdr_acc |=> (last_tag == $past(in_data[6:5])));

  assert_tag_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!hdr_acc && !$past(rst)) |=> $stable(last_tag));
endmodule

bind cmd_frame_router cfr_checker u_cfr_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .in_ready  (in_ready),
  .loc_valid (loc_valid),
  .loc_data  (loc_data),
  .loc_first (loc_first),
  .loc_last  (loc_last),
  .loc_ready (loc_ready),
  .rem_valid (rem_valid),
  .rem_data  (rem_data),
  .rem_first (rem_first),
  .rem_last  (rem_last),
  .rem_ready (rem_ready),
  .last_tag  (last_tag),
  .hdr_err   (hdr_err)
);

// File: tb/cmd_frame_router_bench.sv
module cmd_frame_router_bench;
  localparam int CYC = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready;
  logic       loc_valid, loc_first, loc_last, loc_ready = 1'b0;
  logic [7:0] loc_data;
  logic       rem_valid, rem_first, rem_last, rem_ready = 1'b0;
  logic [7:0] rem_data;
  logic [1:0] last_tag;
  logic       hdr_err;

  always #(CYC/2) clk = ~clk;

  cmd_frame_router u_cmd_frame_router (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .loc_valid(loc_valid), .loc_data(loc_data), .loc_first(loc_first), .loc_last(loc_last),
    .loc_ready(loc_ready), .rem_valid(rem_valid), .rem_data(rem_data), .rem_first(rem_first),
    .rem_last(rem_last), .rem_ready(rem_ready), .last_tag(last_tag), .hdr_err(hdr_err)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  bit         m_hdr = 1;
  int         m_cnt = 0;
  bit         m_loc = 0;
  logic [1:0] m_tag = 0;
  bit         m_err = 0;
  logic [7:0] q[$];
  bit         held = 0;
  int         pv = 100, pr = 100;
  int         exp_loc_n = 0, exp_rem_n = 0, obs_loc_n = 0, obs_rem_n = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int plen(input logic [1:0] c);
    case (c)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 32;
      default: return 512;
    endcase
  endfunction

  task automatic push_frame(input logic [7:0] h);
    int n = plen(h[1:0]);
    q.push_back(h);
    for (int i = 0; i < n; i++) q.push_back(8'(i * 7) ^ h);
    if (h[4:3] == 2'd0) exp_loc_n += n + 1;
    else                exp_rem_n += n + 1;
  endtask

  task automatic model_reset();
    m_hdr = 1; m_cnt = 0; m_loc = 0; m_tag = 0; m_err = 0; held = 0;
  endtask

  task automatic step();
    bit sel, erdy, acc, elast;
    @(negedge clk);
    if (!held) in_valid = (q.size() > 0) && ($urandom_range(99) < pv);
    in_data   = (q.size() > 0) ? q[0] : 8'h00;
    loc_ready = ($urandom_range(99) < pr);
    rem_ready = ($urandom_range(99) < pr);
    #1;
    sel   = m_hdr ? (in_data[4:3] == 2'd0) : m_loc;
    erdy  = sel ? loc_ready : rem_ready;
    elast = !m_hdr && (m_cnt == 1);
    chk(in_ready === erdy, "R6/R7", "in_ready", in_ready, erdy);
    chk(loc_valid === (in_valid && sel), "R3/R10", "loc_valid", loc_valid, in_valid && sel);
    chk(rem_valid === (in_valid && !sel), "R4/R10", "rem_valid", rem_valid, in_valid && !sel);
    chk(!(loc_valid && rem_valid), "R7", "both valid", loc_valid + rem_valid, 1);
    chk(hdr_err === m_err, "R8", "hdr_err", hdr_err, m_err);
    chk(last_tag === m_tag, "R9", "last_tag", last_tag, m_tag);
    if (in_valid && sel) begin
      chk(loc_data === in_data, "R3", "loc_data", loc_data, in_data);
      chk(loc_first === m_hdr, "R5", "loc_first", loc_first, m_hdr);
      chk(loc_last === elast, "R2", "loc_last", loc_last, elast);
    end
    if (in_valid && !sel) begin
      chk(rem_data === in_data, "R4", "rem_data", rem_data, in_data);
      chk(rem_first === m_hdr, "R5", "rem_first", rem_first, m_hdr);
      chk(rem_last === elast, "R2", "rem_last", rem_last, elast);
    end
    if (loc_valid && loc_ready) obs_loc_n++;
    if (rem_valid && rem_ready) obs_rem_n++;
    acc = in_valid && erdy;
    @(posedge clk);
    m_err = 0;
    if (acc) begin
      void'(q.pop_front());
      held = 0;
      if (m_hdr) begin
        m_cnt = plen(in_data[1:0]);
        m_loc = sel;
        m_tag = in_data[6:5];
        m_err = in_data[2];
        m_hdr = 0;
      end else begin
        m_cnt--;
        if (m_cnt == 0) m_hdr = 1;
      end
    end else begin
      held = in_valid;
    end
  endtask

  task automatic drain(input int limit);
    int n = 0;
    while ((q.size() > 0 || held) && n < limit) begin
      step();
      n++;
    end
    repeat (3) step();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; in_valid = 0; in_data = 8'h00;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
    model_reset();
    #1;
    chk(loc_valid === 1'b0, "R1", "loc_valid after reset", loc_valid, 0);
    chk(rem_valid === 1'b0, "R1", "rem_valid after reset", rem_valid, 0);
    chk(hdr_err === 1'b0, "R1", "hdr_err after reset", hdr_err, 0);
    chk(last_tag === 2'd0, "R1", "last_tag after reset", last_tag, 0);
  endtask

  task automatic count_check(input string tag);
    chk(obs_loc_n == exp_loc_n, "R2/R3", {tag, " local bytes"}, obs_loc_n, exp_loc_n);
    chk(obs_rem_n == exp_rem_n, "R2/R4", {tag, " remote bytes"}, obs_rem_n, exp_rem_n);
  endtask

  initial begin
    #(CYC * 190000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    do_reset();

    // directed frames, no stalls, back to back
    pv = 100; pr = 100;
    push_frame(8'h00);   // local, 1 byte (R3)
    push_frame(8'h13);   // endpoint 2, 512 bytes (R4)
    push_frame(8'h1a);   // endpoint 3, 32 bytes
    push_frame(8'h09);   // endpoint 1, 4 bytes
    push_frame(8'h84);   // bit7 + bit2 set, local, 1 byte (R8, R10)
    push_frame(8'h7e);   // tag 3, endpoint 3, bit2 set, 32 bytes (R8)
    push_frame(8'h60);   // tag 3, local
    push_frame(8'hcd);   // bit7, tag 2, endpoint 1, bit2, 4 bytes
    drain(5000);
    count_check("directed");

    // random headers with back-pressure on both sides
    pv = 70; pr = 60;
    for (int i = 0; i < 40; i++) begin
      logic [7:0] h = 8'($urandom);
      if (h[1:0] == 2'd3 && (i % 4) != 0) h[1:0] = 2'd1;
      push_frame(h);
    end
    drain(60000);
    count_check("random");

    // reset in the middle of a remote frame (R1)
    pv = 100; pr = 100;
    push_frame(8'h13);
    repeat (20) step();
    q.delete();
    do_reset();
    obs_loc_n = 0; obs_rem_n = 0; exp_loc_n = 0; exp_rem_n = 0;
    push_frame(8'h00);
    push_frame(8'h25);
    drain(2000);
    count_check("after reset R1");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule